// File: doc/BRIEF.md
# Dual-Channel Serial ADC Host Controller

This block is the host side of a chip-select framed serial link to a two-input, 12-bit converter. It makes the chip-select and the serial clock from the system clock. During each 16-clock word it sends the input channel for the next conversion on the data-in line, and it collects the 12 result bits that the converter returns MSB first. The serial clock comes from a programmable divider with a 50% duty cycle. Between frames the clock rests high, so the first falling edge the converter sees comes after chip-select falls.

The user starts a frame with a request. The request gives the number of 16-clock words in the frame, the first channel, an option to swap channels from one word to the next, and the half-period of the serial clock. The converter selects its input one word ahead, so each result arrives with the channel sent in the word before it. The first result after reset has no such predecessor and is marked with a separate flag.

The controller is a five-state machine:
- `S_IDLE`: chip-select high, clock parked high, ready for a request.
- `S_SETUP`: chip-select low, clock still high, for one half-period.
- `S_SHIFT`: the clock toggles every half-period.
- `S_HOLD`: after the last rising edge, chip-select is held low for one half-period.
- `S_GAP`: chip-select high for one full clock period.

Transitions:
- `S_IDLE` to `S_SETUP` on an accepted request.
- `S_SETUP` to `S_SHIFT` on the first falling edge.
- `S_SHIFT` to `S_HOLD` on the 16th rising edge of the last word.
- `S_HOLD` to `S_GAP` when chip-select rises.
- `S_GAP` to `S_IDLE` after two half-periods.

Top module: `adc2ch_host`

## Requirements
- R1: After reset, chip-select and the serial clock are high, data-in is low, `res_valid` is low and `req_ready` is high.
- R2: Inside a frame, every high and every low phase of the serial clock lasts `req_half`+1 system clocks. The time from chip-select falling to the first falling edge also lasts `req_half`+1 system clocks. The value of `req_half` is captured when the request is accepted.
- R3: A frame holds exactly 16×(`req_extra`+1) rising serial-clock edges. Chip-select rises only while the serial clock is high, one half-period after the last rising edge.
- R4: Data-in changes only on a falling serial-clock edge. It carries the channel bit during clock 5 of each word (word bit 11, where bit 15 is sent first) and is low during every other clock.
- R5: The result is taken from data-out on the rising edges of clocks 5 to 16 of a word, MSB first, and is presented on `res_data`.
- R6: Each result carries in `res_chan` the channel bit sent during the previous word, even when that word was in an earlier frame. `res_first` is high only on the first result after reset.
- R7: With `req_alt` high, the channel sent swaps on every word of the frame, starting from `req_chan`. With `req_alt` low, every word sends `req_chan`.
- R8: Between frames, chip-select stays high for at least 2×(`req_half`+1) system clocks, where `req_half` is the value of the frame that just ended. `req_ready` is high only while chip-select is high.
- R9: Data-out is ignored while chip-select is high and during clocks 1 to 4 of each word.
- R10: `res_valid` is a one-cycle pulse, one pulse per word. It rises in the system cycle after the rising serial-clock edge of clock 16.
- R11: A request made while `req_ready` is low is ignored and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe for a frame |
| req_ready | output | 1 | High while a request can be accepted |
| req_half | input | DIV_W | Serial-clock half-period minus one, in system clocks |
| req_extra | input | CNT_W | Number of words in the frame minus one |
| req_chan | input | 1 | Channel sent in the first word |
| req_alt | input | 1 | Swap the channel on every word |
| adc_cs_n | output | 1 | Chip-select to the converter, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_din | output | 1 | Serial data to the converter (channel address) |
| adc_dout | input | 1 | Serial data from the converter |
| res_valid | output | 1 | Result strobe |
| res_data | output | 12 | Conversion result |
| res_chan | output | 1 | Channel that the result belongs to |
| res_first | output | 1 | First result after reset; its channel is unknown |

## Verification
The 16th rising edge of a word does several things in the same system cycle. It captures the last result bit and issues the result with its tag. It advances or swaps the channel for the next word. In the last word it also ends the frame. Multi-word frames with channel swapping and a half-period of zero place the following falling edge (the one that drives the next channel bit) only one system clock later. A bench model of the converter returns per-channel values set for each frame. Each result is judged on its data, its tag from the previous word, its first flag and the count of rising edges in its frame.

// File: rtl/adc2ch_pkg.sv
package adc2ch_pkg;
    localparam int WORD_CLKS  = 16;
    localparam int DATA_BITS  = 12;
    localparam int DATA_FIRST = 5;
    localparam int CHAN_CLK   = 5;
    localparam int BIT_W      = $clog2(WORD_CLKS);

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_SHIFT,
        S_HOLD,
        S_GAP
    } host_state_e;
endpackage

// File: rtl/adc2ch_half_timer.sv
module adc2ch_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q == half);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!en || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R2: the phase counter never runs past the captured half-period
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> cnt_q <= half);
endmodule

// File: rtl/adc2ch_rx_shift.sv
module adc2ch_rx_shift #(
    parameter int BITS = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            bit_in,
    output logic [BITS-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word <= '0;
        else if (shift_en)
            word <= {word[BITS-2:0], bit_in};
    end
endmodule

// File: rtl/adc2ch_host.sv
module adc2ch_host
    import adc2ch_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [DIV_W-1:0]     req_half,
    input  logic [CNT_W-1:0]     req_extra,
    input  logic                 req_chan,
    input  logic                 req_alt,
    output logic                 adc_cs_n,
    output logic                 adc_sclk,
    output logic                 adc_din,
    input  logic                 adc_dout,
    output logic                 res_valid,
    output logic [DATA_BITS-1:0] res_data,
    output logic                 res_chan,
    output logic                 res_first
);
    localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(WORD_CLKS - 1);
    localparam logic [BIT_W-1:0] CHAN_IDX = BIT_W'(CHAN_CLK - 1);
    localparam logic [BIT_W-1:0] DATA_IDX = BIT_W'(DATA_FIRST - 1);

    host_state_e      state_q, state_d;
    logic [DIV_W-1:0] half_q;
    logic [CNT_W-1:0] words_q;
    logic [BIT_W-1:0] bit_q;
    logic             alt_q, chan_q, last_chan_q, have_last_q, gap_q;
    logic             cs_n_q, sclk_q, din_q;
    logic             res_valid_q, res_chan_q, res_first_q;
    logic             tick, rise_tick, fall_tick, sample_en;

    adc2ch_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q != S_IDLE),
        .half  (half_q),
        .tick  (tick)
    );

    assign rise_tick = (state_q == S_SHIFT) && tick && !sclk_q;
    assign fall_tick = (state_q == S_SHIFT) && tick && sclk_q;
    assign sample_en = rise_tick && (bit_q >= DATA_IDX);

    adc2ch_rx_shift #(.BITS(DATA_BITS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sample_en),
        .bit_in   (adc_dout),
        .word     (res_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = S_SETUP;
            S_SETUP: if (tick) state_d = S_SHIFT;
            S_SHIFT: if (rise_tick && bit_q == LAST_IDX && words_q == '0)
                         state_d = S_HOLD;
            S_HOLD:  if (tick) state_d = S_GAP;
            S_GAP:   if (tick && gap_q) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q      <= 1'b1;
            sclk_q      <= 1'b1;
            din_q       <= 1'b0;
            half_q      <= '0;
            words_q     <= '0;
            bit_q       <= '0;
            alt_q       <= 1'b0;
            chan_q      <= 1'b0;
            last_chan_q <= 1'b0;
            have_last_q <= 1'b0;
            gap_q       <= 1'b0;
            res_valid_q <= 1'b0;
            res_chan_q  <= 1'b0;
            res_first_q <= 1'b0;
        end else begin
            res_valid_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    sclk_q <= 1'b1;
                    din_q  <= 1'b0;
                    gap_q  <= 1'b0;
                    if (req_valid) begin
                        half_q  <= req_half;
                        words_q <= req_extra;
                        alt_q   <= req_alt;
                        chan_q  <= req_chan;
                        bit_q   <= '0;
                        cs_n_q  <= 1'b0;
                    end
                end
                S_SETUP: begin
                    if (tick) begin
                        sclk_q <= 1'b0;
                        din_q  <= 1'b0;
                    end
                end
                S_SHIFT: begin
                    if (fall_tick) begin
                        sclk_q <= 1'b0;
                        din_q  <= (bit_q == CHAN_IDX) ? chan_q : 1'b0;
                    end else if (rise_tick) begin
                        sclk_q <= 1'b1;
                        bit_q  <= bit_q + 1'b1;
                        if (bit_q == LAST_IDX) begin
                            res_valid_q <= 1'b1;
                            res_chan_q  <= last_chan_q;
                            res_first_q <= !have_last_q;
                            have_last_q <= 1'b1;
                            last_chan_q <= chan_q;
                            if (words_q != '0) begin
                                words_q <= words_q - 1'b1;
                                if (alt_q)
                                    chan_q <= ~chan_q;
                            end
                        end
                    end
                end
                S_HOLD: begin
                    if (tick)
                        cs_n_q <= 1'b1;
                end
                S_GAP: begin
                    if (tick)
                        gap_q <= ~gap_q;
                end
                default: ;
            endcase
        end
    end

    assign req_ready = (state_q == S_IDLE);
    assign adc_cs_n  = cs_n_q;
    assign adc_sclk  = sclk_q;
    assign adc_din   = din_q;
    assign res_valid = res_valid_q;
    assign res_chan  = res_chan_q;
    assign res_first = res_first_q;

    // R1: clock rests high whenever chip-select is high
    a_r1_sclk_parked: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_q |-> sclk_q);

    // R3: chip-select rises only after the clock has been high
    a_r3_cs_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_q) |-> (sclk_q && $past(sclk_q)));

    // R4: data-in moves only with a falling serial-clock edge inside a frame
    a_r4_din_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(din_q) && !cs_n_q) |-> $fell(sclk_q));

    // R8: ready only while the link is deselected
    a_r8_ready_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cs_n_q);

    // R10: result strobe lasts one cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_q |=> !res_valid_q);
endmodule

// File: tb/adc2ch_host_tb.sv
`timescale 1ns/1ps
module adc2ch_host_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_half = '0;
    logic [3:0]  req_extra = '0;
    logic        req_chan = 1'b0;
    logic        req_alt = 1'b0;
    logic        adc_cs_n, adc_sclk, adc_din;
    logic        adc_dout = 1'b0;
    logic        res_valid;
    logic [11:0] res_data;
    logic        res_chan, res_first;

    always #4 clk = ~clk;

    adc2ch_host u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_half(req_half), .req_extra(req_extra),
        .req_chan(req_chan), .req_alt(req_alt),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din),
        .adc_dout(adc_dout),
        .res_valid(res_valid), .res_data(res_data),
        .res_chan(res_chan), .res_first(res_first)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // converter model and expectation queues
    logic [11:0] vals [2];
    int  k = 0;
    int  rises = 0;
    logic mux_cur = 1'b0;
    logic mux_next = 1'b0;
    int  sent_q[$];
    int  rise_q[$];
    int  exp_data_q[$];
    int  exp_chan_q[$];
    int  exp_first_q[$];
    int  prev_sent = -1;
    int  cur_half = 0;
    int  gap_need = 0;
    int  frames_req = 0;
    int  cs_falls = 0;

    always @(negedge adc_cs_n) begin
        k = 0;
        rises = 0;
        cs_falls++;
    end

    always @(negedge adc_sclk) begin
        if (adc_cs_n === 1'b0) begin
            k = k + 1;
            if (k >= 5) adc_dout = vals[mux_cur][16-k];
            else        adc_dout = 1'($urandom);
        end
    end

    always @(posedge adc_sclk) begin
        if (adc_cs_n === 1'b0) begin
            rises++;
            if (k == 5) begin
                int e;
                e = (sent_q.size() > 0) ? sent_q.pop_front() : -1;
                chk(adc_din == 1'(e), "R4/R7 channel bit on clock 5", int'(adc_din), e);
                mux_next = adc_din;
            end else begin
                chk(adc_din == 1'b0, "R4 idle address bit", int'(adc_din), 0);
            end
            if (k == 16) begin
                mux_cur = mux_next;
                k = 0;
            end
        end
    end

    always @(posedge adc_cs_n) begin
        if (rise_q.size() > 0) begin
            int e;
            e = rise_q.pop_front();
            chk(rises == e, "R3 rising edges per frame", rises, e);
            chk(adc_sclk == 1'b1, "R3 clock high at frame end", int'(adc_sclk), 1);
        end
        gap_need = 2 * (cur_half + 1);
    end

    // cycle monitors, sampled away from the active edge
    logic prev_sclk = 1'b1, prev_cs = 1'b1, prev_din = 1'b0, prev_rv = 1'b0;
    int   run_len = 0;
    bit   have_run = 1'b0;
    int   gap_len = 0;
    bit   seen_frame = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            adc_dout = adc_cs_n ? 1'($urandom) : adc_dout;
            // R2 phase lengths
            if (!adc_cs_n) begin
                if (prev_cs) begin
                    run_len = 1;
                    have_run = 1'b1;
                    if (seen_frame)
                        chk(gap_len >= gap_need, "R8 chip-select high time", gap_len, gap_need);
                    seen_frame = 1'b1;
                end else if (adc_sclk != prev_sclk) begin
                    if (have_run)
                        chk(run_len == cur_half + 1, "R2 half-period length", run_len, cur_half + 1);
                    run_len = 1;
                end else begin
                    run_len++;
                end
                if (adc_din != prev_din)
                    chk(prev_sclk && !adc_sclk, "R4 data-in moves on falling edge", int'(adc_sclk), 0);
            end else begin
                have_run = 1'b0;
                gap_len = prev_cs ? gap_len + 1 : 1;
                if (req_ready)
                    chk(adc_cs_n == 1'b1, "R8 ready only when deselected", int'(adc_cs_n), 1);
            end
            // results
            if (res_valid) begin
                chk(!prev_rv, "R10 single-cycle strobe", int'(prev_rv), 0);
                if (exp_data_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected result", 1, 0);
                end else begin
                    int ed, ec, ef;
                    ed = exp_data_q.pop_front();
                    ec = exp_chan_q.pop_front();
                    ef = exp_first_q.pop_front();
                    chk(res_data == 12'(ed), "R5/R9 result data", int'(res_data), ed);
                    chk(res_first == 1'(ef), "R6 first flag", int'(res_first), ef);
                    if (ef == 0)
                        chk(res_chan == 1'(ec), "R6 channel tag of previous word", int'(res_chan), ec);
                end
            end
            prev_rv   = res_valid;
            prev_sclk = adc_sclk;
            prev_cs   = adc_cs_n;
            prev_din  = adc_din;
        end
    end

    task automatic do_frame(input int half, input int extra, input bit ch, input bit alt);
        while (!req_ready) @(negedge clk);
        vals[0] = 12'($urandom);
        vals[1] = 12'($urandom);
        for (int w = 0; w <= extra; w++) begin
            int s;
            s = alt ? int'(ch ^ 1'(w & 1)) : int'(ch);
            sent_q.push_back(s);
            if (prev_sent < 0) begin
                exp_data_q.push_back(int'(vals[0]));
                exp_chan_q.push_back(0);
                exp_first_q.push_back(1);
            end else begin
                exp_data_q.push_back(int'(vals[prev_sent]));
                exp_chan_q.push_back(prev_sent);
                exp_first_q.push_back(0);
            end
            prev_sent = s;
        end
        rise_q.push_back(16 * (extra + 1));
        cur_half  = half;
        req_half  = 8'(half);
        req_extra = 4'(extra);
        req_chan  = ch;
        req_alt   = alt;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        frames_req++;
    endtask

    task automatic drain();
        while (!(req_ready && exp_data_q.size() == 0)) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5EED_0A2C));
        vals[0] = '0;
        vals[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(adc_cs_n == 1'b1, "R1 chip-select idle", int'(adc_cs_n), 1);
        chk(adc_sclk == 1'b1, "R1 clock parked", int'(adc_sclk), 1);
        chk(adc_din == 1'b0, "R1 data-in idle", int'(adc_din), 0);
        chk(res_valid == 1'b0, "R1 no result", int'(res_valid), 0);
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);

        // directed corners
        do_frame(0, 0, 1'b1, 1'b0);   // first result, fastest clock
        drain();
        do_frame(2, 0, 1'b0, 1'b0);
        drain();
        do_frame(0, 3, 1'b0, 1'b1);   // R7 swapping, tight edges
        drain();
        do_frame(3, 2, 1'b1, 1'b0);
        // R11 request while busy
        repeat (20) @(negedge clk);
        req_half  = 8'd1;
        req_extra = 4'd5;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        drain();
        repeat (30) @(negedge clk);
        chk(cs_falls == frames_req, "R11 busy request ignored", cs_falls, frames_req);

        // constrained random frames
        for (int i = 0; i < 24; i++) begin
            do_frame($urandom_range(0, 4), $urandom_range(0, 3),
                     1'($urandom), 1'($urandom));
            if (($urandom & 1) != 0) drain();
        end
        drain();
        chk(cs_falls == frames_req, "R3 frame count", cs_falls, frames_req);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule